// File: doc/BRIEF.md
# Level Alarm Monitor with Hysteresis

This block watches a stream of ADC conversion results on one channel and tracks two alarms. The high alarm starts when a result climbs past a trip level and ends only when a result drops below a separate, lower release level. The low alarm mirrors this: it starts below a trip level and ends above a higher release level. The gap between trip and release is a hysteresis band, so a signal that hovers near one level does not make the alarm toggle. A typical band is about 30 codes.

Each alarm start and each alarm end sets its own sticky flag. Software clears a flag by writing a one to its bit. A single interrupt line is the OR of the flags whose enables are set. The block also sorts each result into one of three classes: high, low or normal. It forwards the result to the data path one cycle later, unless the discard control for that class is set. The alarms work only while the channel runs in periodic sampling mode.

Top module: `lvl_alarm_top`

## Requirements
- R1: Each threshold word carries the trip level in bits 11:0 and the release level in bits 27:16. The other bits are ignored.
- R2: An inactive high alarm becomes active on a sample strictly greater than its trip level. That sample sets flag bit 20 (high start). A sample equal to the trip level does not start the alarm.
- R3: An active high alarm ends on a sample strictly below its release level, which sets flag bit 21 (high end). Samples at or above the release level keep the alarm active.
- R4: An inactive low alarm becomes active on a sample strictly below its trip level, which sets flag bit 22 (low start). A sample equal to the trip level does not start it.
- R5: An active low alarm ends on a sample strictly above its release level, which sets flag bit 23 (low end).
- R6: Flags are set only on a change of alarm state. Further samples that stay in the alarm region set nothing, even after the flag has been cleared.
- R7: Bit 0 of the alarm control word enables the high alarm and bit 1 enables the low alarm. When an alarm is disabled, or when periodic_mode is low, its state is cleared without setting any flag.
- R8: After a sample is evaluated, it is classed high if the high alarm is active, otherwise low if the low alarm is active, otherwise normal. Alarm control bits 4, 5 and 6 drop high, low and normal samples respectively. A sample that is not dropped appears on fwd_data with fwd_valid high one cycle after it is accepted.
- R9: A write on flag_wr with a 1 in bits 20 to 23 of flag_wdata clears those flags. A 0, or any other bit, has no effect. A flag set in the same cycle as its clear stays set.
- R10: irq is high when at least one flag is set and its enable is set. Enable bits 4 to 7 of int_ctrl map to flags 20 to 23 in the same order. irq is registered: it follows flag changes on the same edge and enable changes on the next edge.
- R11: After reset, all flags, irq and fwd_valid are 0 and both alarms are inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| periodic_mode | input | 1 | Channel runs periodic sampling; alarms only work when high |
| smp_valid | input | 1 | New ADC result present |
| smp_data | input | 12 | ADC result |
| hi_thr_word | input | 32 | High alarm trip level [11:0], release level [27:16] |
| lo_thr_word | input | 32 | Low alarm trip level [11:0], release level [27:16] |
| alarm_ctrl | input | 32 | Alarm enables [1:0], class discards [6:4] |
| int_ctrl | input | 32 | Interrupt enables [7:4] |
| flag_wr | input | 1 | Write strobe for flag clear |
| flag_wdata | input | 32 | Write-one-to-clear mask, flags in [23:20] |
| fwd_valid | output | 1 | Forwarded sample valid |
| fwd_data | output | 12 | Forwarded sample |
| flag_word | output | 32 | Sticky flags in [23:20], other bits zero |
| irq | output | 1 | Combined interrupt |

## Verification
The bench drives samples exactly on each trip and release level. A design that compares with the wrong inequality would start or end an alarm one code early at those points. It holds samples inside the hysteresis band and in the alarm region after a flag has been cleared. A design that is level-sensitive rather than edge-sensitive would set flags again there. It disables an alarm while the alarm is active and then re-enables it. A design that keeps stale state would report a false end event. It also lines up a clear with a set in the same cycle, and steps the interrupt enables past flags that are already set. A design that gives the clear priority, or leaves irq unregistered against its enables, would fail those checks.

// File: rtl/lvl_alarm_pkg.sv
package lvl_alarm_pkg;
  // Field positions software relies on
  localparam int TRIP_LSB    = 0;
  localparam int RELEASE_LSB = 16;
  localparam int FLAG_LSB    = 20;
  localparam int IEN_LSB     = 4;
  localparam int HI_EN_BIT   = 0;
  localparam int LO_EN_BIT   = 1;
  localparam int DISC_LSB    = 4;
  localparam int N_EVT       = 4;
  localparam int N_DISC      = 3;

  typedef enum logic {DIR_HIGH, DIR_LOW} alarm_dir_e;
  typedef enum logic [1:0] {CLS_NORMAL, CLS_HIGH, CLS_LOW} smp_class_e;

  typedef struct packed {
    logic ended;
    logic started;
  } alarm_evt_t;
endpackage

// File: rtl/lvl_alarm_det.sv
module lvl_alarm_det
  import lvl_alarm_pkg::*;
#(
  parameter int         SMP_W = 12,
  parameter alarm_dir_e DIR   = DIR_HIGH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic             smp_valid,
  input  logic [SMP_W-1:0] smp_data,
  input  logic [SMP_W-1:0] trip_lvl,
  input  logic [SMP_W-1:0] rel_lvl,
  output logic             active_q,
  output logic             active_nxt,
  output alarm_evt_t       evt
);
  logic trip_hit;
  logic rel_hit;

  generate
    if (DIR == DIR_HIGH) begin : g_high
      assign trip_hit = smp_data > trip_lvl;
      assign rel_hit  = smp_data < rel_lvl;
    end else begin : g_low
      assign trip_hit = smp_data < trip_lvl;
      assign rel_hit  = smp_data > rel_lvl;
    end
  endgenerate

  always_comb begin
    active_nxt = active_q;
    evt        = '0;
    if (!arm) begin
      active_nxt = 1'b0;
    end else if (smp_valid) begin
      if (!active_q && trip_hit) begin
        active_nxt  = 1'b1;
        evt.started = 1'b1;
      end else if (active_q && rel_hit) begin
        active_nxt = 1'b0;
        evt.ended  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) active_q <= 1'b0;
    else     active_q <= active_nxt;
  end

  // R7
  disarm_clears_chk: assert property (@(posedge clk) disable iff (rst)
    !arm |=> !active_q);

  // R6
  start_needs_sample_chk: assert property (@(posedge clk) disable iff (rst)
    !active_q && active_nxt |-> smp_valid && arm);
endmodule

// File: rtl/lvl_alarm_gate.sv
module lvl_alarm_gate
  import lvl_alarm_pkg::*;
#(
  parameter int SMP_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_valid,
  input  logic [SMP_W-1:0]  smp_data,
  input  logic              hi_active,
  input  logic              lo_active,
  input  logic [N_DISC-1:0] discard,
  output logic              fwd_valid,
  output logic [SMP_W-1:0]  fwd_data
);
  smp_class_e cls;
  logic       drop;

  always_comb begin
    if (hi_active)      cls = CLS_HIGH;
    else if (lo_active) cls = CLS_LOW;
    else                cls = CLS_NORMAL;
    case (cls)
      CLS_HIGH: drop = discard[0];
      CLS_LOW:  drop = discard[1];
      default:  drop = discard[2];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_valid <= 1'b0;
      fwd_data  <= '0;
    end else begin
      fwd_valid <= smp_valid && !drop;
      if (smp_valid) fwd_data <= smp_data;
    end
  end

  // R8
  fwd_origin_chk: assert property (@(posedge clk) disable iff (rst)
    fwd_valid |-> $past(smp_valid) && fwd_data == $past(smp_data));
endmodule

// File: rtl/lvl_alarm_flags.sv
module lvl_alarm_flags
  import lvl_alarm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [N_EVT-1:0] set_evt,
  input  logic             clr_wr,
  input  logic [N_EVT-1:0] clr_mask,
  input  logic [N_EVT-1:0] ien,
  output logic [N_EVT-1:0] flags_q,
  output logic             irq_q
);
  logic [N_EVT-1:0] flags_nxt;

  always_comb begin
    flags_nxt = flags_q;
    if (clr_wr) flags_nxt = flags_nxt & ~clr_mask;
    flags_nxt = flags_nxt | set_evt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      flags_q <= flags_nxt;
      irq_q   <= |(flags_nxt & ien);
    end
  end

  // R6
  flag_origin_chk: assert property (@(posedge clk) disable iff (rst)
    (flags_q & ~$past(flags_q) & ~$past(set_evt)) == '0);

  // R10
  irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> (flags_q & $past(ien)) != '0);
endmodule

// File: rtl/lvl_alarm_top.sv
module lvl_alarm_top
  import lvl_alarm_pkg::*;
#(
  parameter int SMP_W = 12,
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             periodic_mode,
  input  logic             smp_valid,
  input  logic [SMP_W-1:0] smp_data,
  input  logic [REG_W-1:0] hi_thr_word,
  input  logic [REG_W-1:0] lo_thr_word,
  input  logic [REG_W-1:0] alarm_ctrl,
  input  logic [REG_W-1:0] int_ctrl,
  input  logic             flag_wr,
  input  logic [REG_W-1:0] flag_wdata,
  output logic             fwd_valid,
  output logic [SMP_W-1:0] fwd_data,
  output logic [REG_W-1:0] flag_word,
  output logic             irq
);
  localparam int N_ALARM = 2;

  logic [REG_W-1:0] thr_word [N_ALARM];
  logic [N_ALARM-1:0] arm;
  logic [N_ALARM-1:0] act_q;
  logic [N_ALARM-1:0] act_nxt;
  alarm_evt_t         evt [N_ALARM];
  logic [N_EVT-1:0]   set_evt;
  logic [N_EVT-1:0]   flags;
  logic               unused_bits;

  assign thr_word[0] = hi_thr_word;
  assign thr_word[1] = lo_thr_word;
  assign arm[0] = periodic_mode && alarm_ctrl[HI_EN_BIT];
  assign arm[1] = periodic_mode && alarm_ctrl[LO_EN_BIT];

  genvar g;
  generate
    for (g = 0; g < N_ALARM; g++) begin : g_alarm
      lvl_alarm_det #(
        .SMP_W (SMP_W),
        .DIR   ((g == 0) ? DIR_HIGH : DIR_LOW)
      ) i_det (
        .clk        (clk),
        .rst        (rst),
        .arm        (arm[g]),
        .smp_valid  (smp_valid),
        .smp_data   (smp_data),
        .trip_lvl   (thr_word[g][TRIP_LSB +: SMP_W]),
        .rel_lvl    (thr_word[g][RELEASE_LSB +: SMP_W]),
        .active_q   (act_q[g]),
        .active_nxt (act_nxt[g]),
        .evt        (evt[g])
      );
      assign set_evt[2*g]   = evt[g].started;
      assign set_evt[2*g+1] = evt[g].ended;
    end
  endgenerate

  lvl_alarm_gate #(.SMP_W(SMP_W)) i_gate (
    .clk       (clk),
    .rst       (rst),
    .smp_valid (smp_valid),
    .smp_data  (smp_data),
    .hi_active (act_nxt[0]),
    .lo_active (act_nxt[1]),
    .discard   (alarm_ctrl[DISC_LSB +: N_DISC]),
    .fwd_valid (fwd_valid),
    .fwd_data  (fwd_data)
  );

  lvl_alarm_flags i_flags (
    .clk      (clk),
    .rst      (rst),
    .set_evt  (set_evt),
    .clr_wr   (flag_wr),
    .clr_mask (flag_wdata[FLAG_LSB +: N_EVT]),
    .ien      (int_ctrl[IEN_LSB +: N_EVT]),
    .flags_q  (flags),
    .irq_q    (irq)
  );

  always_comb begin
    flag_word = '0;
    flag_word[FLAG_LSB +: N_EVT] = flags;
  end

  assign unused_bits = ^{hi_thr_word, lo_thr_word, alarm_ctrl, int_ctrl, flag_wdata, act_q};

  // R2
  hi_start_flag_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(act_q[0]) |-> flag_word[FLAG_LSB]);

  // R4
  lo_start_flag_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(act_q[1]) |-> flag_word[FLAG_LSB+2]);

  // R3
  hi_end_flag_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(act_q[0]) && $past(arm[0]) && arm[0] |-> flag_word[FLAG_LSB+1]);

  // R5
  lo_end_flag_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(act_q[1]) && $past(arm[1]) && arm[1] |-> flag_word[FLAG_LSB+3]);
endmodule

// File: tb/test_lvl_alarm_top.sv
module test_lvl_alarm_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        periodic_mode;
  logic        smp_valid;
  logic [11:0] smp_data;
  logic [31:0] hi_thr_word;
  logic [31:0] lo_thr_word;
  logic [31:0] alarm_ctrl;
  logic [31:0] int_ctrl;
  logic        flag_wr;
  logic [31:0] flag_wdata;
  logic        fwd_valid;
  logic [11:0] fwd_data;
  logic [31:0] flag_word;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;

  localparam logic [31:0] F_HS = 32'h0010_0000;
  localparam logic [31:0] F_HE = 32'h0020_0000;
  localparam logic [31:0] F_LS = 32'h0040_0000;
  localparam logic [31:0] F_LE = 32'h0080_0000;
  localparam logic [31:0] F_ALL = 32'h00F0_0000;

  always #5 clk = ~clk;

  lvl_alarm_top i_lvl_alarm_top (
    .clk(clk), .rst(rst), .periodic_mode(periodic_mode),
    .smp_valid(smp_valid), .smp_data(smp_data),
    .hi_thr_word(hi_thr_word), .lo_thr_word(lo_thr_word),
    .alarm_ctrl(alarm_ctrl), .int_ctrl(int_ctrl),
    .flag_wr(flag_wr), .flag_wdata(flag_wdata),
    .fwd_valid(fwd_valid), .fwd_data(fwd_data),
    .flag_word(flag_word), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic push(input logic [11:0] s);
    @(negedge clk);
    smp_valid = 1'b1;
    smp_data  = s;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic clear(input logic [31:0] m);
    @(negedge clk);
    flag_wr    = 1'b1;
    flag_wdata = m;
    @(negedge clk);
    flag_wr    = 1'b0;
  endtask

  task automatic t_reset;
    chk("R11 flags", flag_word, 32'h0);
    chk("R11 irq", {31'h0, irq}, 32'h0);
    chk("R11 fwd_valid", {31'h0, fwd_valid}, 32'h0);
  endtask

  task automatic t_high;
    push(12'd2000);
    chk("R8 normal forwarded", {19'h0, fwd_valid, fwd_data}, {19'h0, 1'b1, 12'd2000});
    chk("R2 below trip", flag_word, 32'h0);
    push(12'd3000);
    chk("R2 equal trip no start", flag_word, 32'h0);
    push(12'd3001);
    chk("R2 start flag", flag_word, F_HS);
    push(12'd3100);
    chk("R6 stay no new flag", flag_word, F_HS);
    clear(F_HS);
    chk("R9 clear start", flag_word, 32'h0);
    push(12'd3050);
    chk("R6 no refire after clear", flag_word, 32'h0);
    push(12'd2980);
    chk("R3 inside band", flag_word, 32'h0);
    push(12'd2970);
    chk("R3 equal release", flag_word, 32'h0);
    push(12'd2969);
    chk("R3 end flag", flag_word, F_HE);
    clear(F_ALL);
  endtask

  task automatic t_low;
    push(12'd500);
    chk("R4 equal trip no start", flag_word, 32'h0);
    push(12'd499);
    chk("R4 start flag", flag_word, F_LS);
    push(12'd530);
    chk("R5 equal release", flag_word, F_LS);
    push(12'd531);
    chk("R5 end flag", flag_word, F_LS | F_LE);
    clear(F_ALL);
    chk("R9 clear all", flag_word, 32'h0);
  endtask

  task automatic t_enable;
    alarm_ctrl = 32'h2;
    push(12'd4000);
    chk("R7 high disabled", flag_word, 32'h0);
    alarm_ctrl = 32'h3;
    periodic_mode = 1'b0;
    push(12'd4000);
    chk("R7 not periodic", flag_word, 32'h0);
    periodic_mode = 1'b1;
    push(12'd4000);
    chk("R7 periodic starts", flag_word, F_HS);
    @(negedge clk);
    alarm_ctrl = 32'h2;
    @(negedge clk);
    alarm_ctrl = 32'h3;
    push(12'd2000);
    chk("R7 disable clears state, no end", flag_word, F_HS);
    clear(F_ALL);
  endtask

  task automatic t_discard;
    alarm_ctrl = 32'h13;
    push(12'd3500);
    chk("R8 high dropped", {31'h0, fwd_valid}, 32'h0);
    push(12'd2000);
    chk("R8 normal after end kept", {19'h0, fwd_valid, fwd_data}, {19'h0, 1'b1, 12'd2000});
    alarm_ctrl = 32'h43;
    push(12'd2001);
    chk("R8 normal dropped", {31'h0, fwd_valid}, 32'h0);
    push(12'd200);
    chk("R8 low kept", {19'h0, fwd_valid, fwd_data}, {19'h0, 1'b1, 12'd200});
    alarm_ctrl = 32'h23;
    push(12'd250);
    chk("R8 low dropped", {31'h0, fwd_valid}, 32'h0);
    push(12'd1000);
    chk("R8 normal kept bit5", {19'h0, fwd_valid, fwd_data}, {19'h0, 1'b1, 12'd1000});
    alarm_ctrl = 32'h3;
    clear(F_ALL);
  endtask

  task automatic t_irq;
    int_ctrl = 32'h10;
    push(12'd3500);
    chk("R10 irq with flag", {31'h0, irq}, 32'h1);
    clear(F_HS);
    chk("R10 irq drops on clear", {31'h0, irq}, 32'h0);
    int_ctrl = 32'h80;
    push(12'd2000);
    push(12'd3500);
    chk("R10 flags set", flag_word, F_HS | F_HE);
    chk("R10 disabled source", {31'h0, irq}, 32'h0);
    @(negedge clk);
    int_ctrl = 32'h30;
    chk("R10 enable not yet seen", {31'h0, irq}, 32'h0);
    @(negedge clk);
    chk("R10 irq after enable", {31'h0, irq}, 32'h1);
    int_ctrl = 32'h0;
    push(12'd2000);
    clear(F_ALL);
  endtask

  task automatic t_w1c;
    push(12'd3500);
    clear(32'h000F_FFFF);
    chk("R9 non-flag bits ignored", flag_word, F_HS);
    @(negedge clk);
    smp_valid  = 1'b1;
    smp_data   = 12'd2000;
    flag_wr    = 1'b1;
    flag_wdata = F_HS | F_HE;
    @(negedge clk);
    smp_valid = 1'b0;
    flag_wr   = 1'b0;
    chk("R9 set beats clear", flag_word, F_HE);
    clear(F_ALL);
  endtask

  task automatic t_fields;
    hi_thr_word = {4'hF, 12'd1990, 4'hF, 12'd2000};
    push(12'd2001);
    chk("R1 trip field", flag_word, F_HS);
    push(12'd1990);
    chk("R1 release equal", flag_word, F_HS);
    push(12'd1989);
    chk("R1 release field", flag_word, F_HS | F_HE);
    hi_thr_word = {4'h0, 12'd2970, 4'h0, 12'd3000};
    clear(F_ALL);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1;
    periodic_mode = 1'b1;
    smp_valid = 1'b0;
    smp_data = '0;
    hi_thr_word = {4'h0, 12'd2970, 4'h0, 12'd3000};
    lo_thr_word = {4'h0, 12'd530, 4'h0, 12'd500};
    alarm_ctrl = 32'h3;
    int_ctrl = 32'h0;
    flag_wr = 1'b0;
    flag_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_high();
    t_low();
    t_enable();
    t_discard();
    t_irq();
    t_w1c();
    t_fields();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule